// File: doc/BRIEF.md
# Descriptor-Chained DMA Transmit Channel

This block is a single transmit channel of a list-driven DMA engine. Software places a chain of data descriptors in memory. Each descriptor names a byte buffer through a start and an end address, carries a link to the next descriptor, and carries two flags: one closes a packet and one closes the list. The channel fetches each descriptor and reads the bytes of its buffer through a word-wide memory port. It stages the bytes in a small internal buffer and then sends them to a byte-wide valid/ready stream.

When a list-closing descriptor completes, the channel marks its context record as disabled. It writes that record back to memory so software can see where the channel stopped, and then it goes idle. Software starts the channel in one of two ways: by loading a context record, or by loading a data descriptor with the burst bit. After the end of the list, it can use a continue command to resume once it has cleared the end-of-list flag of the last descriptor.

Top module: `dma_out_chan`

## Requirements
- R1: A pass moves `min(end - saved_buf, STAGE_BYTES)` bytes in ascending address order, starting at the saved buffer pointer. Each byte is taken from lane `addr[1:0]` of the little-endian word at `addr & ~3`.
- R2: After each pass the saved buffer pointer (register 0x08) grows by the pass length. A descriptor is complete when that pointer equals its end address, so a descriptor with start equal to end completes without moving any bytes.
- R3: `st_last_o` is high only on the final byte of a descriptor whose flags word has bit 1 (end of packet) set.
- R4: When a descriptor whose flags word has bit 0 (end of list) set completes, the channel takes four steps in order. It sets status bit 5. It writes the 3-word context record (descriptor pointer, buffer pointer, flags) to the address in the context pointer register (0x00), with bit 0 of the flags word set. It writes the descriptor back. It then returns to idle.
- R5: When a descriptor without end of list completes, several registers are updated. The saved descriptor pointer (0x04) takes its next field, the descriptor at that address is fetched, and the saved buffer pointer takes the new buffer start. Streaming then continues.
- R6: A descriptor is four words in this order: next, start, end, flags. After each completion, the descriptor at the saved descriptor pointer is written back unchanged.
- R7: Command bit 0 (load data) fetches the descriptor at the saved descriptor pointer and copies that address into the current descriptor register (0x0C). It leaves the saved buffer pointer unchanged. The channel streams only if command bit 2 (burst) is also set.
- R8: Command bit 1 (load context) reads the context record at the context pointer and loads the descriptor and buffer pointers from it. It clears the end-of-list status, fetches that descriptor and starts streaming. It takes priority over bit 0.
- R9: Command bit 3 (continue) re-reads the descriptor at the current descriptor register. The channel restarts only if that descriptor's end-of-list bit is now clear and status bit 5 is set. To restart, it fetches the descriptor at the next field and streams from its buffer start. Otherwise nothing else changes.
- R10: The status register (0x14) has three fields:
  - bits [2:0] give the state: 0 idle, 1 streaming, 2 descriptor or context traffic;
  - bit 5 gives the end-of-list status;
  - bit 8 holds command bit 9 from the last command write.
  Command bits above 9 are ignored, and all register writes are ignored unless the channel is idle.
- R11: Register decoding uses the address modulo 0x2000.
- R12: Data and last marker on the stream stay stable while valid is high and ready is low. When `st_attached_i` is low, valid stays low and each byte is counted in the drop register (0x18) instead.
- R13: A memory request holds its address, direction and write data until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 16 | Register byte address (decoded modulo 0x2000) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write when high, read when low |
| mem_addr_o | output | 32 | Memory word address (byte address, word aligned) |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata_i | input | 32 | Memory read data |
| st_valid_o | output | 1 | Stream byte valid |
| st_data_o | output | 8 | Stream byte |
| st_last_o | output | 1 | Final byte of a packet |
| st_ready_i | input | 1 | Stream sink ready |
| st_attached_i | input | 1 | A stream sink is present |

## Verification
The assertions assume well-formed chains: every descriptor's end address is not below its start, and software sets the saved buffer pointer inside the buffer it starts from. They also assume `st_attached_i` does not change during a pass, and that read data is valid in the cycle of the acknowledge. The stimulus keeps to these assumptions. It builds each chain with random offsets and lengths but always with `end >= start`, and it changes the sink-present input only while the channel is idle. Ready and memory acknowledge are randomized cycle by cycle so that both stall paths are exercised.

// File: rtl/dma_out_pkg.sv
package dma_out_pkg;

  localparam logic [12:0] OFF_CTX   = 13'h000;
  localparam logic [12:0] OFF_SDESC = 13'h004;
  localparam logic [12:0] OFF_SBUF  = 13'h008;
  localparam logic [12:0] OFF_CDESC = 13'h00C;
  localparam logic [12:0] OFF_CMD   = 13'h010;
  localparam logic [12:0] OFF_STAT  = 13'h014;
  localparam logic [12:0] OFF_DROP  = 13'h018;

  localparam int CMD_LOADD = 0;
  localparam int CMD_LOADC = 1;
  localparam int CMD_BURST = 2;
  localparam int CMD_CONT  = 3;
  localparam int CMD_SRC   = 9;

  localparam int FLG_EOL = 0;
  localparam int FLG_EOP = 1;
  localparam int CTX_DIS = 0;

  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_RUN  = 3'd1;
  localparam logic [2:0] ST_MEM  = 3'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_CTX_RD, S_DESC_RD, S_RUN, S_FILL, S_PUSH, S_CTX_WR, S_DESC_WR
  } state_e;

  typedef enum logic [2:0] {
    OP_LOADD, OP_CTX, OP_CONT, OP_RESTART, OP_CHAIN
  } op_e;

  typedef struct packed {
    logic [31:0] next;
    logic [31:0] start;
    logic [31:0] stop;
    logic [31:0] flags;
  } desc_t;

endpackage

// File: rtl/dma_out_stage.sv
module dma_out_stage #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [7:0]    wr_byte_i,
  input  logic          start_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          last_i,
  output logic          done_o,
  output logic          st_valid_o,
  output logic [7:0]    st_data_o,
  output logic          st_last_o,
  input  logic          st_ready_i,
  input  logic          attached_i,
  output logic [31:0]   drop_cnt_o
);

  logic [7:0]    buf_q [DEPTH];
  logic          busy_q, last_q, done_q;
  logic [CW-1:0] rd_idx_q, cnt_q;
  logic [31:0]   drop_q;
  logic          fire, final_beat;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) buf_q[wr_idx_i] <= wr_byte_i;
  end

  assign fire       = busy_q && (st_ready_i || !attached_i);
  assign final_beat = (rd_idx_q == cnt_q - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      last_q   <= 1'b0;
      done_q   <= 1'b0;
      rd_idx_q <= '0;
      cnt_q    <= '0;
      drop_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q   <= 1'b1;
        cnt_q    <= cnt_i;
        last_q   <= last_i;
        rd_idx_q <= '0;
      end else if (fire) begin
        if (!attached_i) drop_q <= drop_q + 32'd1;
        if (final_beat) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          rd_idx_q <= rd_idx_q + CW'(1);
        end
      end
    end
  end

  assign st_valid_o = busy_q && attached_i;
  assign st_data_o  = buf_q[rd_idx_q[IW-1:0]];
  assign st_last_o  = busy_q && last_q && final_beat;
  assign done_o     = done_q;
  assign drop_cnt_o = drop_q;

  p_pass_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (cnt_i != '0) && (cnt_i <= CW'(DEPTH)));
  p_start_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  p_valid_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_o && !st_ready_i |=> st_valid_o && $stable(st_data_o) && $stable(st_last_o));

endmodule

// File: rtl/dma_out_ctrl.sv
module dma_out_ctrl
  import dma_out_pkg::*;
#(
  parameter int STAGE_BYTES = 16,
  localparam int IW = $clog2(STAGE_BYTES),
  localparam int CW = $clog2(STAGE_BYTES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [15:0]   reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [31:0]   mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          stg_wr_o,
  output logic [IW-1:0] stg_idx_o,
  output logic [7:0]    stg_byte_o,
  output logic          stg_start_o,
  output logic [CW-1:0] stg_cnt_o,
  output logic          stg_last_o,
  input  logic          stg_done_i,
  input  logic [31:0]   drop_cnt_i
);

  state_e        state_q;
  op_e           op_q;
  desc_t         desc_q;
  logic [1:0]    wcnt_q;
  logic [31:0]   base_q, ctx_ptr_q, saved_desc_q, saved_buf_q, cur_desc_q, ctx_flags_q;
  logic          eol_q, src_q, burst_q, pass_last_q;
  logic [CW-1:0] fill_idx_q, pass_len_q;

  logic [12:0]   off;
  logic [9:0]    cmd;
  logic [31:0]   rem, byte_addr;
  logic [CW-1:0] pass_len_n;
  logic          ack, fill_end;
  logic [2:0]    st_code;
  logic          unused_hi;

  assign off       = reg_addr_i[12:0];
  assign cmd       = reg_wdata_i[9:0];
  assign unused_hi = ^{reg_addr_i[15:13]};
  assign rem       = desc_q.stop - saved_buf_q;
  assign pass_len_n = (rem > 32'(STAGE_BYTES)) ? CW'(STAGE_BYTES) : rem[CW-1:0];
  assign byte_addr = saved_buf_q + 32'(fill_idx_q);
  assign ack       = mem_req_o && mem_ack_i;
  assign fill_end  = (fill_idx_q == pass_len_q - CW'(1));

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = base_q + {28'd0, wcnt_q, 2'b00};
    mem_wdata_o = '0;
    case (state_q)
      S_CTX_RD, S_DESC_RD: mem_req_o = 1'b1;
      S_FILL: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {byte_addr[31:2], 2'b00};
      end
      S_CTX_WR: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        case (wcnt_q)
          2'd0:    mem_wdata_o = saved_desc_q;
          2'd1:    mem_wdata_o = saved_buf_q;
          default: mem_wdata_o = ctx_flags_q;
        endcase
      end
      S_DESC_WR: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        case (wcnt_q)
          2'd0:    mem_wdata_o = desc_q.next;
          2'd1:    mem_wdata_o = desc_q.start;
          2'd2:    mem_wdata_o = desc_q.stop;
          default: mem_wdata_o = desc_q.flags;
        endcase
      end
      default: ;
    endcase
  end

  assign stg_wr_o    = (state_q == S_FILL) && ack;
  assign stg_idx_o   = fill_idx_q[IW-1:0];
  assign stg_byte_o  = mem_rdata_i[8*byte_addr[1:0] +: 8];
  assign stg_start_o = stg_wr_o && fill_end;
  assign stg_cnt_o   = pass_len_q;
  assign stg_last_o  = pass_last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      op_q         <= OP_LOADD;
      desc_q       <= '0;
      wcnt_q       <= '0;
      base_q       <= '0;
      ctx_ptr_q    <= '0;
      saved_desc_q <= '0;
      saved_buf_q  <= '0;
      cur_desc_q   <= '0;
      ctx_flags_q  <= '0;
      eol_q        <= 1'b0;
      src_q        <= 1'b0;
      burst_q      <= 1'b0;
      pass_last_q  <= 1'b0;
      fill_idx_q   <= '0;
      pass_len_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (reg_we_i) begin
          case (off)
            OFF_CTX:   ctx_ptr_q    <= reg_wdata_i;
            OFF_SDESC: saved_desc_q <= reg_wdata_i;
            OFF_SBUF:  saved_buf_q  <= reg_wdata_i;
            OFF_CMD: begin
              src_q  <= cmd[CMD_SRC];
              wcnt_q <= '0;
              if (cmd[CMD_LOADC]) begin
                base_q  <= ctx_ptr_q;
                eol_q   <= 1'b0;
                state_q <= S_CTX_RD;
              end else if (cmd[CMD_LOADD]) begin
                base_q  <= saved_desc_q;
                op_q    <= OP_LOADD;
                burst_q <= cmd[CMD_BURST];
                if (cmd[CMD_BURST]) eol_q <= 1'b0;
                state_q <= S_DESC_RD;
              end else if (cmd[CMD_CONT]) begin
                base_q  <= cur_desc_q;
                op_q    <= OP_CONT;
                state_q <= S_DESC_RD;
              end
            end
            default: ;
          endcase
        end
        S_CTX_RD: if (ack) begin
          case (wcnt_q)
            2'd0: saved_desc_q <= mem_rdata_i;
            2'd1: saved_buf_q  <= mem_rdata_i;
            default: begin
              ctx_flags_q <= mem_rdata_i;
              base_q      <= saved_desc_q;
              op_q        <= OP_CTX;
            end
          endcase
          if (wcnt_q == 2'd2) begin
            wcnt_q  <= '0;
            state_q <= S_DESC_RD;
          end else begin
            wcnt_q <= wcnt_q + 2'd1;
          end
        end
        S_DESC_RD: if (ack) begin
          case (wcnt_q)
            2'd0:    desc_q.next  <= mem_rdata_i;
            2'd1:    desc_q.start <= mem_rdata_i;
            2'd2:    desc_q.stop  <= mem_rdata_i;
            default: desc_q.flags <= mem_rdata_i;
          endcase
          wcnt_q <= wcnt_q + 2'd1;
          if (wcnt_q == 2'd3) begin
            cur_desc_q <= base_q;
            case (op_q)
              OP_LOADD: state_q <= burst_q ? S_RUN : S_IDLE;
              OP_CTX:   state_q <= S_RUN;
              OP_CONT: begin
                if (!mem_rdata_i[FLG_EOL] && eol_q) begin
                  saved_desc_q <= desc_q.next;
                  base_q       <= desc_q.next;
                  op_q         <= OP_RESTART;
                end else begin
                  state_q <= S_IDLE;
                end
              end
              OP_RESTART: begin
                saved_buf_q <= desc_q.start;
                eol_q       <= 1'b0;
                state_q     <= S_RUN;
              end
              default: begin
                saved_buf_q <= desc_q.start;
                state_q     <= S_DESC_WR;
              end
            endcase
          end
        end
        S_RUN: begin
          wcnt_q <= '0;
          if (saved_buf_q == desc_q.stop) begin
            if (desc_q.flags[FLG_EOL]) begin
              eol_q                <= 1'b1;
              ctx_flags_q[CTX_DIS] <= 1'b1;
              base_q               <= ctx_ptr_q;
              state_q              <= S_CTX_WR;
            end else begin
              saved_desc_q <= desc_q.next;
              base_q       <= desc_q.next;
              op_q         <= OP_CHAIN;
              state_q      <= S_DESC_RD;
            end
          end else begin
            pass_len_q  <= pass_len_n;
            pass_last_q <= desc_q.flags[FLG_EOP] && (rem <= 32'(STAGE_BYTES));
            fill_idx_q  <= '0;
            state_q     <= S_FILL;
          end
        end
        S_FILL: if (ack) begin
          if (fill_end) state_q <= S_PUSH;
          else          fill_idx_q <= fill_idx_q + CW'(1);
        end
        S_PUSH: if (stg_done_i) begin
          saved_buf_q <= saved_buf_q + 32'(pass_len_q);
          state_q     <= S_RUN;
        end
        S_CTX_WR: if (ack) begin
          if (wcnt_q == 2'd2) begin
            wcnt_q  <= '0;
            base_q  <= saved_desc_q;
            state_q <= S_DESC_WR;
          end else begin
            wcnt_q <= wcnt_q + 2'd1;
          end
        end
        S_DESC_WR: if (ack) begin
          wcnt_q <= wcnt_q + 2'd1;
          if (wcnt_q == 2'd3) state_q <= eol_q ? S_IDLE : S_RUN;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      S_IDLE:                st_code = ST_IDLE;
      S_RUN, S_FILL, S_PUSH: st_code = ST_RUN;
      default:               st_code = ST_MEM;
    endcase
  end

  always_comb begin
    reg_rdata_o = '0;
    case (off)
      OFF_CTX:   reg_rdata_o = ctx_ptr_q;
      OFF_SDESC: reg_rdata_o = saved_desc_q;
      OFF_SBUF:  reg_rdata_o = saved_buf_q;
      OFF_CDESC: reg_rdata_o = cur_desc_q;
      OFF_DROP:  reg_rdata_o = drop_cnt_i;
      OFF_STAT: begin
        reg_rdata_o[2:0] = st_code;
        reg_rdata_o[5]   = eol_q;
        reg_rdata_o[8]   = src_q;
      end
      default: ;
    endcase
  end

  p_req_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                && $stable(mem_wdata_o));
  p_buf_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RUN) |-> (saved_buf_q <= desc_q.stop));
  p_eol_store_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eol_q) |-> (state_q == S_CTX_WR) && ctx_flags_q[CTX_DIS]);
  p_push_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stg_done_i |-> (state_q == S_PUSH));

endmodule

// File: rtl/dma_out_chan.sv
module dma_out_chan #(
  parameter int STAGE_BYTES = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [15:0] reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_ack_i,
  input  logic [31:0] mem_rdata_i,
  output logic        st_valid_o,
  output logic [7:0]  st_data_o,
  output logic        st_last_o,
  input  logic        st_ready_i,
  input  logic        st_attached_i
);

  localparam int IW = $clog2(STAGE_BYTES);
  localparam int CW = $clog2(STAGE_BYTES + 1);

  logic          stg_wr, stg_start, stg_last, stg_done;
  logic [IW-1:0] stg_idx;
  logic [7:0]    stg_byte;
  logic [CW-1:0] stg_cnt;
  logic [31:0]   drop_cnt;

  dma_out_ctrl #(.STAGE_BYTES(STAGE_BYTES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .stg_wr_o    (stg_wr),
    .stg_idx_o   (stg_idx),
    .stg_byte_o  (stg_byte),
    .stg_start_o (stg_start),
    .stg_cnt_o   (stg_cnt),
    .stg_last_o  (stg_last),
    .stg_done_i  (stg_done),
    .drop_cnt_i  (drop_cnt)
  );

  dma_out_stage #(.DEPTH(STAGE_BYTES)) u_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (stg_wr),
    .wr_idx_i   (stg_idx),
    .wr_byte_i  (stg_byte),
    .start_i    (stg_start),
    .cnt_i      (stg_cnt),
    .last_i     (stg_last),
    .done_o     (stg_done),
    .st_valid_o (st_valid_o),
    .st_data_o  (st_data_o),
    .st_last_o  (st_last_o),
    .st_ready_i (st_ready_i),
    .attached_i (st_attached_i),
    .drop_cnt_o (drop_cnt)
  );

endmodule

// File: tb/dma_out_chan_tb.sv
module dma_out_chan_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        st_valid, st_last;
  logic [7:0]  st_data;
  logic        st_ready = 1'b0;
  logic        attach = 1'b1;
  logic        stall = 1'b0;

  logic [31:0] mem [256];
  logic [7:0]  got_d[$], exp_d[$];
  logic        got_l[$], exp_l[$];
  int          nchk = 0, nerr = 0;
  int          cycles = 0;
  logic [31:0] last_desc, last_end;

  always #2.5 clk = ~clk;

  dma_out_chan u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .st_valid_o(st_valid), .st_data_o(st_data), .st_last_o(st_last),
    .st_ready_i(st_ready), .st_attached_i(attach)
  );

  assign mem_ack   = mem_req && !stall;
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (mem_req && mem_ack && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    #1;
    stall    = ($urandom % 10) < 3;
    st_ready = attach && (($urandom % 10) < 7);
    cycles++;
  end

  always @(negedge clk) begin
    if (st_valid && st_ready) begin
      got_d.push_back(st_data);
      got_l.push_back(st_last);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      rd(16'h14, s);
      if (s[2:0] == 3'd0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return mem[a[9:2]][8*a[1:0] +: 8];
  endfunction

  task automatic put_desc(input logic [31:0] a, input logic [31:0] nx, st, en, fl);
    mem[a[9:2]] = nx; mem[a[9:2]+1] = st; mem[a[9:2]+2] = en; mem[a[9:2]+3] = fl;
  endtask

  task automatic add_exp(input logic [31:0] st, input int len, input bit eop);
    for (int j = 0; j < len; j++) begin
      exp_d.push_back(mbyte(st + j));
      exp_l.push_back(eop && (j == len - 1));
    end
  endtask

  task automatic cmp_stream(input string tag);
    int bad_d = 0, bad_l = 0;
    chk(got_d.size() == exp_d.size(), {tag, " byte count"}, got_d.size(), exp_d.size());
    if (got_d.size() == exp_d.size())
      for (int k = 0; k < got_d.size(); k++) begin
        if (got_d[k] != exp_d[k]) bad_d++;
        if (got_l[k] != exp_l[k]) bad_l++;
      end
    chk(bad_d == 0, {tag, " R1 byte order/data mismatches"}, bad_d, 0);
    chk(bad_l == 0, {tag, " R3 last marker mismatches"}, bad_l, 0);
    got_d.delete(); got_l.delete(); exp_d.delete(); exp_l.delete();
  endtask

  // builds a chain of n descriptors at 0x10*i, buffers at 0x100+0x40*i
  task automatic build_chain(input int n, input int maxlen, output int total);
    total = 0;
    for (int w = 64; w < 192; w++) mem[w] = $urandom;
    for (int i = 0; i < n; i++) begin
      logic [31:0] st, en, fl, nx;
      int len;
      len = $urandom % (maxlen + 1);
      st  = 32'h100 + 32'h40 * i + ($urandom % 4);
      en  = st + len;
      fl  = {30'd0, 1'($urandom % 2), 1'(i == n - 1)};
      nx  = (i == n - 1) ? 32'h0 : 32'h10 * (i + 1);
      put_desc(32'h10 * i, nx, st, en, fl);
      add_exp(st, len, fl[1]);
      total += len;
      last_desc = 32'h10 * i;
      last_end  = en;
    end
    mem[60] = 32'h0; mem[61] = mem[1]; mem[62] = 32'h0;   // context at 0xF0
  endtask

  task automatic ctx_trial(input int n, input int maxlen, input string tag);
    logic [31:0] v;
    int total;
    build_chain(n, maxlen, total);
    wr(16'h00, 32'hF0);
    wr(16'h10, 32'h2);
    wait_idle();
    cmp_stream(tag);
    rd(16'h14, v);
    chk(v[5] == 1'b1 && v[2:0] == 3'd0, {tag, " R4 eol status, stopped"}, v, 32'h20);
    chk(mem[62][0] == 1'b1, {tag, " R4 context disable bit"}, mem[62], 32'h1);
    chk(mem[60] == last_desc, {tag, " R4 context desc ptr"}, mem[60], last_desc);
    rd(16'h04, v);
    chk(v == last_desc, {tag, " R5 saved desc ptr"}, v, last_desc);
    rd(16'h08, v);
    chk(v == last_end, {tag, " R2 saved buf ptr at end"}, v, last_end);
    chk(mem[last_desc[9:2]+2] == last_end, {tag, " R6 desc write-back"},
        mem[last_desc[9:2]+2], last_end);
  endtask

  initial begin
    logic [31:0] v, d0;
    int total;
    void'($urandom(32'd1234));
    for (int w = 0; w < 256; w++) mem[w] = '0;
    repeat (3) @(negedge clk);
    rd(16'h14, v);
    chk(v == 32'h0, "R10 reset status", v, 0);
    chk(!st_valid && !mem_req, "R12 reset outputs quiet", {30'd0, st_valid, mem_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11 aliasing
    wr(16'h2008, 32'hCAFE0008);
    rd(16'h0008, v);
    chk(v == 32'hCAFE0008, "R11 modulo 0x2000 alias", v, 32'hCAFE0008);

    // R10 src bit and ignored high command bits
    wr(16'h10, 32'h0000_0600);
    rd(16'h14, v);
    chk(v == 32'h100, "R10 src bit, no op from high bits", v, 32'h100);

    // R1 R3 R5 random chains from a context
    for (int t = 0; t < 6; t++) ctx_trial(1 + $urandom % 4, 40, "R8 chain");
    ctx_trial(1, 0, "R2 zero-length");

    // R9 continue while eol still set: no change
    wr(16'h10, 32'h8);
    wait_idle();
    rd(16'h14, v);
    chk(v[5] == 1'b1 && got_d.size() == 0, "R9 continue ignored while eol set", v, 32'h20);

    // R9 clear eol, link to new descriptor, continue restarts
    for (int w = 192; w < 208; w++) mem[w] = $urandom;
    put_desc(32'h80, 32'h0, 32'h301, 32'h31A, 32'h3);
    mem[last_desc[9:2]]   = 32'h80;
    mem[last_desc[9:2]+3] = 32'h0;
    add_exp(32'h301, 25, 1'b1);
    wr(16'h10, 32'h8);
    wait_idle();
    cmp_stream("R9 continue restart");
    rd(16'h04, v);
    chk(v == 32'h80, "R9 saved desc after restart", v, 32'h80);
    rd(16'h08, v);
    chk(v == 32'h31A, "R9 saved buf after restart", v, 32'h31A);

    // R7 load data without burst: fetch only, saved buf untouched
    put_desc(32'h40, 32'h0, 32'h304, 32'h30C, 32'h3);
    wr(16'h04, 32'h40);
    wr(16'h08, 32'h1234_5678);
    wr(16'h10, 32'h1);
    wait_idle();
    rd(16'h0C, v);
    chk(v == 32'h40, "R7 current desc reg", v, 32'h40);
    rd(16'h08, v);
    chk(v == 32'h1234_5678, "R7 saved buf unchanged by data load", v, 32'h1234_5678);
    chk(got_d.size() == 0, "R7 no stream without burst", got_d.size(), 0);

    // R7 load data with burst
    wr(16'h08, 32'h304);
    wr(16'h10, 32'h5);
    add_exp(32'h304, 8, 1'b1);
    wait_idle();
    cmp_stream("R7 burst");

    // R12 detached sink: bytes dropped and counted
    attach = 1'b0;
    rd(16'h18, d0);
    build_chain(2, 30, total);
    exp_d.delete(); exp_l.delete();
    wr(16'h00, 32'hF0);
    wr(16'h10, 32'h2);
    wait_idle();
    rd(16'h18, v);
    chk(v - d0 == total, "R12 drop count when detached", v - d0, total);
    chk(got_d.size() == 0, "R12 no valid when detached", got_d.size(), 0);
    attach = 1'b1;

    // R10 writes ignored while busy
    build_chain(1, 40, total);
    wr(16'h00, 32'hF0);
    wr(16'h10, 32'h2);
    wr(16'h00, 32'h55);
    wait_idle();
    cmp_stream("R10 busy");
    rd(16'h00, v);
    chk(v == 32'hF0, "R10 write ignored while busy", v, 32'hF0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    nchk++; nerr++;
    $display("FAIL watchdog act=%0d exp=<150000", cycles);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule